// File: doc/BRIEF.md
# Trace Synchronization Period Counter

This block counts the bytes a trace unit emits and raises a one-cycle synchronization request each time a programmed power-of-two number of bytes has gone out. The interval is held as a base-2 exponent in a 5-bit field of a 32-bit control register. The packet encoder reports the byte count for each cycle on a narrow input. It turns each request pulse into a synchronization packet, and whatever overshoot the last cycle produced is carried into the next interval.

Software reaches the register through a simple one-request, one-response port. The block tracks whether the trace unit is idle or running. It refuses writes while running, and it refuses every access while the external lock input is high. An exponent of zero turns the requests off. Exponents that fall outside the legal window also give no requests, so the block behaves the same way on every run.

Top module: `sync_period_ctr`

## Requirements
- R1: After a synchronous reset, the period exponent is 0, `sync_req` is 0 and `rsp_valid` is 0.
- R2: The register sits at byte offset 0x034. Bits [4:0] hold the period exponent and can be read and written. Bits [31:5] read as 0 and ignore writes. Every access gets a response on `rsp_valid` in the next cycle. A read returns the register value held before that access's clock edge. A write returns 0 data.
- R3: While `lock_in` is high, any access returns `rsp_err`=1 with 0 data, and a write has no effect.
- R4: A write while running returns `rsp_err`=1 and is ignored. A read while running succeeds. An access to any offset other than 0x034 returns `rsp_err`=1 with 0 data and has no effect.
- R5: For exponents 8 to 20 inclusive, a request is raised once the running count reaches 2^exponent bytes. `trace_bytes` adds 0 to 4 bytes per running cycle, and values 5 to 7 count as 4.
- R6: `sync_req` is a one-cycle pulse, high in the cycle after the clock edge at which the count reached or crossed the threshold. The amount above the threshold becomes the starting count of the next interval.
- R7: An exponent of 0, or any value outside 8 to 20, raises no requests and holds the count at zero.
- R8: The count clears when the unit moves from idle to running, and whenever an accepted write changes the exponent value. While idle, `trace_bytes` is ignored.
- R9: The running state follows `trace_en` one clock later. Write refusal and counting use that registered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_en | input | 1 | Trace unit enable; high requests running |
| trace_bytes | input | 3 | Trace bytes emitted this cycle |
| lock_in | input | 1 | Access denied; all accesses return an error |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data |
| sync_req | output | 1 | One-cycle synchronization request |

## Verification
A corrupted byte count shows up at `sync_req`: the pulse comes early, late or never, within one period of at most 2^20/4 cycles, and the next pulse is off by the same amount. A wrong exponent or a lost refusal can be seen on the very next read response, and it also moves the spacing of the pulses. A wrong running state turns an idle write into an error, or a running write into a success, in the response one cycle later.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int REG_W     = 32;
  localparam int EXP_W     = 5;
  localparam int ADDR_W    = 12;
  localparam int BYTES_W   = 3;
  localparam int MAX_BYTES = 4;
  localparam int MIN_EXP   = 8;
  localparam int MAX_EXP   = 20;
  localparam int CNT_W     = MAX_EXP + 2;
  localparam logic [ADDR_W-1:0] PERIOD_OFS = 12'h034;

  function automatic logic exp_legal(input logic [EXP_W-1:0] e);
    return (e >= EXP_W'(MIN_EXP)) && (e <= EXP_W'(MAX_EXP));
  endfunction
endpackage

// File: rtl/spc_state.sv
module spc_state (
  input  logic clk,
  input  logic rst,
  input  logic trace_en,
  output logic run_q,
  output logic start
);
  assign start = trace_en & ~run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= trace_en;
  end
endmodule

// File: rtl/spc_regs.sv
module spc_regs
  import spc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run_q,
  input  logic              lock_in,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [REG_W-1:0]  acc_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [REG_W-1:0]  rsp_rdata,
  output logic [EXP_W-1:0]  period_q,
  output logic              exp_changed
);
  logic hit, err, wr_ok;

  always_comb begin
    hit         = (acc_addr == PERIOD_OFS);
    err         = lock_in | ~hit | (acc_write & run_q);
    wr_ok       = acc_valid & acc_write & ~err;
    exp_changed = wr_ok & (acc_wdata[EXP_W-1:0] != period_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q  <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_err   <= acc_valid & err;
      rsp_rdata <= (acc_valid & ~err & ~acc_write) ? REG_W'(period_q) : '0;
      if (wr_ok) period_q <= acc_wdata[EXP_W-1:0];
    end
  end
endmodule

// File: rtl/spc_counter.sv
module spc_counter
  import spc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               run_q,
  input  logic               start,
  input  logic               clr,
  input  logic [EXP_W-1:0]   period_q,
  input  logic [BYTES_W-1:0] trace_bytes,
  output logic               sync_req
);
  logic [CNT_W-1:0] cnt_q, sum, thr, inc;
  logic             legal;

  always_comb begin
    legal = exp_legal(period_q);
    thr   = CNT_W'(1) << period_q;
    inc   = (trace_bytes > BYTES_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : CNT_W'(trace_bytes);
    sum   = cnt_q + inc;
  end

  always_ff @(posedge clk) begin
    if (rst || start || clr || !legal) begin
      cnt_q    <= '0;
      sync_req <= 1'b0;
    end else if (run_q) begin
      if (sum >= thr) begin
        cnt_q    <= sum - thr;
        sync_req <= 1'b1;
      end else begin
        cnt_q    <= sum;
        sync_req <= 1'b0;
      end
    end else begin
      sync_req <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_period_ctr.sv
module sync_period_ctr
  import spc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               trace_en,
  input  logic [BYTES_W-1:0] trace_bytes,
  input  logic               lock_in,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [REG_W-1:0]   acc_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [REG_W-1:0]   rsp_rdata,
  output logic               sync_req
);
  logic             run_q, start, exp_changed;
  logic [EXP_W-1:0] period_q;

  spc_state u_state (
    .clk(clk), .rst(rst), .trace_en(trace_en), .run_q(run_q), .start(start)
  );

  spc_regs u_regs (
    .clk(clk), .rst(rst), .run_q(run_q), .lock_in(lock_in),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .period_q(period_q), .exp_changed(exp_changed)
  );

  spc_counter u_cnt (
    .clk(clk), .rst(rst), .run_q(run_q), .start(start), .clr(exp_changed),
    .period_q(period_q), .trace_bytes(trace_bytes), .sync_req(sync_req)
  );
endmodule

// File: rtl/spc_checker.sv
module spc_checker
  import spc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic             acc_write,
  input logic             lock_in,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [REG_W-1:0] rsp_rdata,
  input logic             sync_req,
  input logic             run_q,
  input logic [EXP_W-1:0] period_q
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_rdata[REG_W-1:EXP_W] == '0));
  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rsp_valid);
  assert_lock_error_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && lock_in) |=> (rsp_err && rsp_rdata == '0));
  assert_run_write_held_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && run_q) |=> ($stable(period_q) && rsp_err));
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    sync_req |=> !sync_req);
  assert_off_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !exp_legal(period_q) |=> !sync_req);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !sync_req);
endmodule

bind sync_period_ctr spc_checker u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
  .lock_in(lock_in), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata), .sync_req(sync_req), .run_q(run_q), .period_q(period_q)
);

// File: tb/sync_period_ctr_test.sv
module sync_period_ctr_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 0, rst = 1, trace_en = 0, lock_in = 0;
  logic        acc_valid = 0, acc_write = 0;
  logic [2:0]  trace_bytes = 0;
  logic [11:0] acc_addr = 0;
  logic [31:0] acc_wdata = 0;
  logic        rsp_valid, rsp_err, sync_req;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  // bench reference state
  bit          m_run;
  logic [4:0]  m_per;
  longint      m_cnt;
  bit          m_req, m_rv, m_re;
  logic [31:0] m_rd;

  sync_period_ctr uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit legal(input logic [4:0] e);
    return e >= 8 && e <= 20;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  task automatic model_edge();
    bit hit, err, wok, clr, start;
    longint b, s, thr;
    hit   = (acc_addr == 12'h034);
    err   = lock_in || !hit || (acc_write && m_run);
    wok   = acc_valid && acc_write && !err;
    clr   = wok && (acc_wdata[4:0] != m_per);
    start = trace_en && !m_run;
    if (start || clr || !legal(m_per)) begin
      m_cnt = 0; m_req = 0;
    end else if (m_run) begin
      b = (trace_bytes > 4) ? 4 : trace_bytes;
      s = m_cnt + b; thr = longint'(1) << m_per;
      if (s >= thr) begin m_req = 1; m_cnt = s - thr; end
      else begin m_req = 0; m_cnt = s; end
    end else m_req = 0;
    m_rv = acc_valid;
    m_re = acc_valid && err;
    m_rd = (acc_valid && !err && !acc_write) ? {27'b0, m_per} : 32'b0;
    m_run = trace_en;
    if (wok) m_per = acc_wdata[4:0];
  endtask

  // one clock: inputs already set at negedge; compare at the following negedge
  task automatic cyc(input string tag);
    @(posedge clk);
    if (!rst) model_edge();
    @(negedge clk);
    cycles++;
    if (!rst) begin
      check({tag, " sync_req R5/R6"}, sync_req, m_req);
      check({tag, " rsp_valid R2"}, rsp_valid, m_rv);
      if (m_rv) begin
        check({tag, " rsp_err R3/R4"}, rsp_err, m_re);
        check({tag, " rsp_rdata R2"}, rsp_rdata, m_rd);
      end
    end
  endtask

  task automatic idle_bus();
    acc_valid = 0; acc_write = 0; acc_addr = 12'h034; acc_wdata = 0;
  endtask

  task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d, input string tag);
    acc_valid = 1; acc_write = wr; acc_addr = a; acc_wdata = d;
    cyc(tag);
    idle_bus();
  endtask

  task automatic stream(input int n, input logic [2:0] b, input string tag);
    trace_bytes = b;
    for (int i = 0; i < n; i++) cyc(tag);
    trace_bytes = 0;
  endtask

  task automatic count_pulses(input int n, input logic [2:0] b, output int p);
    p = 0; trace_bytes = b;
    for (int i = 0; i < n; i++) begin cyc("pulse"); if (sync_req) p++; end
    trace_bytes = 0;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int p;
    void'($urandom(32'h5A17));
    idle_bus();
    @(negedge clk); @(negedge clk);
    rst = 0;
    m_run = 0; m_per = 0; m_cnt = 0; m_req = 0; m_rv = 0; m_re = 0; m_rd = 0;
    check("R1 reset sync_req", sync_req, 0);
    check("R1 reset rsp_valid", rsp_valid, 0);
    access(0, 12'h034, 0, "R1 reset read");
    check("R1 reset exponent", rsp_rdata, 0);

    // R2: reserved bits dropped
    access(1, 12'h034, 32'hFFFF_FFE8, "R2 write");
    access(0, 12'h034, 0, "R2 read");
    check("R2 readback", rsp_rdata, 32'h8);

    // R5/R6: 4 bytes per cycle, exponent 8 -> pulse on the 64th cycle
    trace_en = 1; cyc("R9 start"); cyc("R9 run");
    stream(63, 3'd4, "R5 ramp");
    check("R5 no early pulse", sync_req, 0);
    stream(1, 3'd4, "R5 hit");
    check("R5 pulse at 256 bytes", sync_req, 1);
    cyc("R6 drop");
    check("R6 single cycle", sync_req, 0);

    // R6 overshoot with 3 bytes/cycle: 3 pulses in 256 cycles (768 bytes)
    count_pulses(256, 3'd3, p);
    check("R6 overshoot pulse count", p, 3);
    // R5 clamp: 7 counts as 4 -> 64 cycles give exactly one pulse (starting residue below 256)
    count_pulses(64, 3'd7, p);
    check("R5 clamp count", p, 1);

    // R4: write while running refused, read allowed
    access(1, 12'h034, 32'h9, "R4 run write");
    access(0, 12'h034, 0, "R4 run read");
    check("R4 exponent held", rsp_rdata, 32'h8);
    access(0, 12'h038, 0, "R4 bad offset");
    check("R4 bad offset err", rsp_err, 1);

    // R3: lock
    trace_en = 0; cyc("R9 stop"); cyc("idle");
    lock_in = 1;
    access(1, 12'h034, 32'h0A, "R3 locked write");
    check("R3 locked err", rsp_err, 1);
    lock_in = 0;
    access(0, 12'h034, 0, "R3 read after lock");
    check("R3 exponent unchanged", rsp_rdata, 32'h8);

    // R8: idle bytes ignored, then restart clears count
    stream(100, 3'd4, "R8 idle bytes");
    access(1, 12'h034, 32'h0A, "R8 set 10");
    trace_en = 1; cyc("R8 start"); cyc("R8 run");
    count_pulses(256, 3'd4, p);
    check("R8 fresh count 1024 bytes", p, 1);

    // R7: reserved and zero exponents quiet
    trace_en = 0; cyc("idle"); cyc("idle");
    access(1, 12'h034, 32'h05, "R7 reserved");
    trace_en = 1; cyc("R7 start");
    count_pulses(300, 3'd4, p);
    check("R7 reserved quiet", p, 0);
    trace_en = 0; cyc("idle"); cyc("idle");
    access(1, 12'h034, 32'h00, "R7 zero");
    trace_en = 1; cyc("R7 start");
    count_pulses(300, 3'd4, p);
    check("R7 zero quiet", p, 0);

    // upper legal bound R5
    trace_en = 0; cyc("idle"); cyc("idle");
    access(1, 12'h034, 32'h14, "R5 exp 20");
    access(0, 12'h034, 0, "R5 read 20");
    check("R5 exp 20 kept", rsp_rdata, 32'h14);
    access(1, 12'h034, 32'h10, "R5 exp 16");
    trace_en = 1; cyc("R5 start");
    count_pulses(16384, 3'd4, p);
    check("R5 exp 16 count", p, 1);

    // random mix, checked every cycle against the reference
    for (int i = 0; i < 40000; i++) begin
      int r;
      logic [4:0] pick [8];
      pick = '{5'd0, 5'd8, 5'd8, 5'd9, 5'd10, 5'd5, 5'd21, 5'd31};
      r = int'($urandom_range(0, 999));
      trace_bytes = 3'($urandom_range(0, 7));
      lock_in = ($urandom_range(0, 19) == 0);
      if (r < 3) trace_en = ~trace_en;
      if (r >= 3 && r < 15) begin
        acc_valid = 1; acc_write = ($urandom_range(0, 1) == 1);
        acc_addr  = ($urandom_range(0, 9) == 0) ? 12'h030 : 12'h034;
        acc_wdata = {$urandom_range(0, 65535), 11'b0, pick[$urandom_range(0, 7)]};
      end
      cyc("R2-rand");
      idle_bus();
    end
    lock_in = 0;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule